// File: doc/BRIEF.md
# Single-Bus Register Datapath with Staged ALU

This block is the register side of a small processor in which every register-to-register move travels over one shared internal bus. Five registers can drive that bus through gated outputs: the program counter, the address field of the instruction register, the accumulator, the memory buffer and the ALU result register. Seven registers can load from it. A control word, applied fresh every cycle by an external sequencer, names the single bus driver, the set of registers that load, the ALU function and the memory strobes.

The ALU is combinational and never sits on the bus directly. One operand comes from the accumulator, the other from a dedicated operand register that is loaded from the bus. The result goes into a result register, which can drive the bus on a later cycle. So a value cannot loop from the ALU output back into its own input within one cycle. Memory is reached only through the address register, which drives the external address, and the memory buffer, which takes read data from the external data input and drives the write data. A control word that enables more than one driver, or that reads and writes the same register, is flagged. All of its effects are then suppressed.

Top module: `single_bus_dp`

## Requirements
- R1: After reset every register is zero: each bus source reads back 0, `mem_addr` is 0 and `ir_opcode` is 0.
- R2: `src_en` is one-hot: bit 0 PC, 1 IR address field, 2 AC, 3 MBR, 4 Z. The enabled register drives `bus_val`. With no bit set, `bus_val` is 0.
- R3: `ld_en` bits are 0 PC, 1 IR, 2 AC, 3 MAR, 4 MBR, 5 Y, 6 Z. Every enabled destination other than Z captures the bus value of the cycle at the rising clock edge, and any number of destinations may load at once.
- R4: When `ld_en[6]` is set, Z captures the ALU result, where `alu_fn` selects 00 AC+Y (modulo 2^W), 01 AC AND Y, 10 Y, 11 NOT AC. Y is loaded only from the bus.
- R5: Z keeps its value until it is loaded again, and it can drive the bus in any later cycle.
- R6: `mem_addr` shows the low AW bits of MAR. When `mem_rd` is set in a legal word, `mem_re` is 1 and MBR captures `mem_rdata` at the rising edge.
- R7: `mem_wdata` always shows MBR. When `mem_wr` is set in a legal word, `mem_we` is 1.
- R8: A word with two or more `src_en` bits set raises `bus_err` in the same cycle, suppresses `mem_re` and `mem_we`, and leaves every register unchanged.
- R9: A word that reads and writes the same register raises `bus_err` with the same suppression. This covers a register enabled both as source and as destination (including Z), and `mem_rd` together with an MBR source, an MBR load or `mem_wr`.
- R10: Add-to-memory works in five words: MAR from the IR address, MBR from memory, Y from MBR, Z as AC+Y, then AC from Z. This leaves AC equal to the old AC plus the memory word.
- R11: The IR source drives only the low AW bits of IR onto the bus, with zeros above them. `ir_opcode` shows the upper W-AW bits of IR.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| src_en | input | 5 | One-hot bus driver select |
| ld_en | input | 7 | Destination load enables |
| alu_fn | input | 2 | ALU function select |
| mem_rd | input | 1 | Load MBR from external read data |
| mem_wr | input | 1 | Request an external write of MBR |
| mem_rdata | input | W | External read data |
| mem_addr | output | AW | External address from MAR |
| mem_wdata | output | W | External write data from MBR |
| mem_re | output | 1 | Qualified read strobe |
| mem_we | output | 1 | Qualified write strobe |
| bus_val | output | W | Current internal bus value |
| bus_err | output | 1 | Illegal control word in this cycle |
| ir_opcode | output | W-AW | Upper field of IR for the decoder |

## Verification
Values enter only through a memory read and are then fanned out over the bus to several destinations at once. This separates a load into every destination from a load into just one. The operand register is filled with a value whose bits differ from the accumulator, so each ALU code gives a distinct result, and add, and, pass and invert cannot be mistaken for one another. Illegal words are tried in each form: two drivers, a Z read with a Z load, an AC self-move, and a memory read clashing with an MBR load. Each is followed by a read-back of the registers the word could have touched, which shows that the load was suppressed and not merely flagged. The five-step add-to-memory sequence closes the run with a carry out of the top bit.

// File: rtl/sbd_pkg.sv
package sbd_pkg;
  localparam int unsigned NSRC = 5;
  localparam int unsigned NDST = 7;

  localparam int unsigned SRC_PC  = 0;
  localparam int unsigned SRC_IR  = 1;
  localparam int unsigned SRC_AC  = 2;
  localparam int unsigned SRC_MBR = 3;
  localparam int unsigned SRC_Z   = 4;

  localparam int unsigned DST_PC  = 0;
  localparam int unsigned DST_IR  = 1;
  localparam int unsigned DST_AC  = 2;
  localparam int unsigned DST_MAR = 3;
  localparam int unsigned DST_MBR = 4;
  localparam int unsigned DST_Y   = 5;
  localparam int unsigned DST_Z   = 6;

  typedef enum logic [1:0] {
    ALU_ADD   = 2'b00,
    ALU_AND   = 2'b01,
    ALU_PASSY = 2'b10,
    ALU_NOTAC = 2'b11
  } alu_fn_e;

  // destination bit that corresponds to the same physical register as a source
  function automatic int unsigned src_dst(input int unsigned s);
    case (s)
      SRC_PC:  return DST_PC;
      SRC_IR:  return DST_IR;
      SRC_AC:  return DST_AC;
      SRC_MBR: return DST_MBR;
      default: return DST_Z;
    endcase
  endfunction
endpackage

// File: rtl/sbd_rst_sync.sv
module sbd_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] sync_q;
  logic [1:0] sync_nxt;

  always_comb sync_nxt = {sync_q[0], 1'b1};

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= sync_nxt;
  end

  assign srst_n = sync_q[1];
endmodule

// File: rtl/sbd_reg.sv
module sbd_reg #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] q_nxt;

  always_comb q_nxt = en ? d : q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_nxt;
  end
endmodule

// File: rtl/sbd_word_check.sv
module sbd_word_check
  import sbd_pkg::*;
(
  input  logic [NSRC-1:0] src_en,
  input  logic [NDST-1:0] ld_en,
  input  logic            mem_rd,
  input  logic            mem_wr,
  output logic            illegal,
  output logic [NDST-1:0] ld_ok,
  output logic            rd_ok,
  output logic            wr_ok
);
  logic seen;
  logic multi;
  logic self_rw;
  logic mem_clash;

  always_comb begin
    seen    = 1'b0;
    multi   = 1'b0;
    self_rw = 1'b0;
    for (int unsigned s = 0; s < NSRC; s++) begin
      if (src_en[s]) begin
        if (seen) multi = 1'b1;
        seen = 1'b1;
        if (ld_en[src_dst(s)]) self_rw = 1'b1;
      end
    end
    mem_clash = mem_rd & (ld_en[DST_MBR] | src_en[SRC_MBR] | mem_wr);
    illegal   = multi | self_rw | mem_clash;
    ld_ok     = illegal ? '0 : ld_en;
    rd_ok     = mem_rd & ~illegal;
    wr_ok     = mem_wr & ~illegal;
  end
endmodule

// File: rtl/sbd_bus_mux.sv
module sbd_bus_mux #(
  parameter int unsigned W    = 16,
  parameter int unsigned NSRC = 5
) (
  input  logic [NSRC-1:0]        src_en,
  input  logic [NSRC-1:0][W-1:0] src_data,
  output logic [W-1:0]           bus
);
  logic [NSRC-1:0][W-1:0] gated;

  for (genvar g = 0; g < NSRC; g++) begin : g_gate
    assign gated[g] = src_data[g] & {W{src_en[g]}};
  end

  always_comb begin
    bus = '0;
    for (int unsigned s = 0; s < NSRC; s++) bus = bus | gated[s];
  end
endmodule

// File: rtl/sbd_alu.sv
module sbd_alu
  import sbd_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic [1:0]   fn,
  input  logic [W-1:0] acc,
  input  logic [W-1:0] opnd,
  output logic [W-1:0] res
);
  always_comb begin
    case (alu_fn_e'(fn))
      ALU_ADD:   res = acc + opnd;
      ALU_AND:   res = acc & opnd;
      ALU_PASSY: res = opnd;
      default:   res = ~acc;
    endcase
  end
endmodule

// File: rtl/single_bus_dp.sv
module single_bus_dp
  import sbd_pkg::*;
#(
  parameter int unsigned W  = 16,
  parameter int unsigned AW = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   src_en,
  input  logic [NDST-1:0]   ld_en,
  input  logic [1:0]        alu_fn,
  input  logic              mem_rd,
  input  logic              mem_wr,
  input  logic [W-1:0]      mem_rdata,
  output logic [AW-1:0]     mem_addr,
  output logic [W-1:0]      mem_wdata,
  output logic              mem_re,
  output logic              mem_we,
  output logic [W-1:0]      bus_val,
  output logic              bus_err,
  output logic [W-AW-1:0]   ir_opcode
);
  localparam int unsigned OPW = W - AW;

  logic                   rst_q_n;
  logic [NDST-1:0]        ld_ok;
  logic                   rd_ok;
  logic                   wr_ok;
  logic                   illegal;
  logic [NSRC-1:0][W-1:0] src_data;
  logic [W-1:0]           bus;
  logic [W-1:0]           alu_res;
  logic [W-1:0]           pc_q, ir_q, ac_q, mbr_q, y_q, z_q;
  logic [AW-1:0]          mar_q;
  logic [W-1:0]           mbr_d;

  sbd_rst_sync u_rst (.clk(clk), .arst_n(rst_n), .srst_n(rst_q_n));

  sbd_word_check u_chk_word (
    .src_en(src_en), .ld_en(ld_en), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .illegal(illegal), .ld_ok(ld_ok), .rd_ok(rd_ok), .wr_ok(wr_ok)
  );

  always_comb begin
    src_data          = '0;
    src_data[SRC_PC]  = pc_q;
    src_data[SRC_IR]  = {{OPW{1'b0}}, ir_q[AW-1:0]};
    src_data[SRC_AC]  = ac_q;
    src_data[SRC_MBR] = mbr_q;
    src_data[SRC_Z]   = z_q;
  end

  sbd_bus_mux #(.W(W), .NSRC(NSRC)) u_bus (
    .src_en(src_en), .src_data(src_data), .bus(bus)
  );

  sbd_alu #(.W(W)) u_alu (.fn(alu_fn), .acc(ac_q), .opnd(y_q), .res(alu_res));

  always_comb mbr_d = rd_ok ? mem_rdata : bus;

  sbd_reg #(.W(W)) u_pc (.clk(clk), .rst_n(rst_q_n), .en(ld_ok[DST_PC]),
    .d(bus), .q(pc_q));
  sbd_reg #(.W(W)) u_ir (.clk(clk), .rst_n(rst_q_n), .en(ld_ok[DST_IR]),
    .d(bus), .q(ir_q));
  sbd_reg #(.W(W)) u_ac (.clk(clk), .rst_n(rst_q_n), .en(ld_ok[DST_AC]),
    .d(bus), .q(ac_q));
  sbd_reg #(.W(AW)) u_mar (.clk(clk), .rst_n(rst_q_n), .en(ld_ok[DST_MAR]),
    .d(bus[AW-1:0]), .q(mar_q));
  sbd_reg #(.W(W)) u_mbr (.clk(clk), .rst_n(rst_q_n),
    .en(ld_ok[DST_MBR] | rd_ok), .d(mbr_d), .q(mbr_q));
  sbd_reg #(.W(W)) u_y (.clk(clk), .rst_n(rst_q_n), .en(ld_ok[DST_Y]),
    .d(bus), .q(y_q));
  sbd_reg #(.W(W)) u_z (.clk(clk), .rst_n(rst_q_n), .en(ld_ok[DST_Z]),
    .d(alu_res), .q(z_q));

  assign mem_addr  = mar_q;
  assign mem_wdata = mbr_q;
  assign mem_re    = rd_ok;
  assign mem_we    = wr_ok;
  assign bus_val   = bus;
  assign bus_err   = illegal;
  assign ir_opcode = ir_q[W-1:AW];
endmodule

// File: rtl/sbd_checker.sv
module sbd_checker #(
  parameter int unsigned W  = 16,
  parameter int unsigned AW = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic [4:0]    src_en,
  input logic [6:0]    ld_en,
  input logic [W-1:0]  mem_rdata,
  input logic [AW-1:0] mem_addr,
  input logic [W-1:0]  mem_wdata,
  input logic          mem_re,
  input logic          mem_we,
  input logic [W-1:0]  bus_val,
  input logic          bus_err
);
  // R8
  multi_src_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(src_en) > 1 |-> bus_err);

  // R8
  err_no_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |-> (!mem_re && !mem_we));

  // R8
  err_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |=> ($stable(mem_addr) && $stable(mem_wdata)));

  // R6
  mem_rd_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_re |=> mem_wdata == $past(mem_rdata));

  // R3
  mar_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_en[3] && !bus_err) |=> mem_addr == $past(bus_val[AW-1:0]));

  // R2
  idle_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    src_en == 5'b0 |-> bus_val == '0);

  // R9
  z_rw_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (src_en[4] && ld_en[6]) |-> bus_err);
endmodule

bind single_bus_dp sbd_checker #(.W(W), .AW(AW)) u_sbd_checker (
  .clk(clk), .rst_n(rst_q_n), .src_en(src_en), .ld_en(ld_en),
  .mem_rdata(mem_rdata), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
  .mem_re(mem_re), .mem_we(mem_we), .bus_val(bus_val), .bus_err(bus_err)
);

// File: tb/single_bus_dp_tb.sv
`timescale 1ns/1ps
module single_bus_dp_tb;
  import sbd_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [4:0]  src_en;
  logic [6:0]  ld_en;
  logic [1:0]  alu_fn;
  logic        mem_rd, mem_wr;
  logic [15:0] mem_rdata;
  logic [11:0] mem_addr;
  logic [15:0] mem_wdata;
  logic        mem_re, mem_we;
  logic [15:0] bus_val;
  logic        bus_err;
  logic [3:0]  ir_opcode;

  int checks = 0;
  int failures = 0;
  logic done = 1'b0;
  logic pend = 1'b0;
  logic [15:0] exp_q[$];
  string       tag_q[$];
  logic [15:0] mem [16];

  always #2 clk = ~clk;

  single_bus_dp u_dut (
    .clk(clk), .rst_n(rst_n), .src_en(src_en), .ld_en(ld_en), .alu_fn(alu_fn),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_rdata(mem_rdata),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_re(mem_re),
    .mem_we(mem_we), .bus_val(bus_val), .bus_err(bus_err), .ir_opcode(ir_opcode)
  );

  assign mem_rdata = mem[mem_addr[3:0]];
  always @(posedge clk) if (mem_we) mem[mem_addr[3:0]] <= mem_wdata;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // scoreboard monitor: compares the bus against queued expectations
  always @(negedge clk) begin
    if (pend && exp_q.size() > 0) begin
      logic [15:0] v;
      string t;
      v = exp_q.pop_front();
      t = tag_q.pop_front();
      chk(t, {16'h0, bus_val}, {16'h0, v});
    end
  end

  task automatic apply(input logic [4:0] s, input logic [6:0] l, input logic [1:0] f,
                       input logic r, input logic w);
    @(posedge clk); #1;
    pend = 1'b0;
    src_en = s; ld_en = l; alu_fn = f; mem_rd = r; mem_wr = w;
  endtask

  task automatic idle();
    apply(5'b0, 7'b0, 2'b00, 1'b0, 1'b0);
  endtask

  // driver: shows one register on the bus and pushes the expected value
  task automatic obs(input int unsigned s, input logic [15:0] v, input string tag);
    apply(5'(1 << s), 7'b0, 2'b00, 1'b0, 1'b0);
    exp_q.push_back(v);
    tag_q.push_back(tag);
    pend = 1'b1;
  endtask

  task automatic mid();
    @(negedge clk);
  endtask

  localparam logic [6:0] L_PC  = 7'(1 << DST_PC);
  localparam logic [6:0] L_IR  = 7'(1 << DST_IR);
  localparam logic [6:0] L_AC  = 7'(1 << DST_AC);
  localparam logic [6:0] L_MAR = 7'(1 << DST_MAR);
  localparam logic [6:0] L_MBR = 7'(1 << DST_MBR);
  localparam logic [6:0] L_Y   = 7'(1 << DST_Y);
  localparam logic [6:0] L_Z   = 7'(1 << DST_Z);

  function automatic logic [4:0] s1(input int unsigned s);
    return 5'(1 << s);
  endfunction

  initial begin
    for (int i = 0; i < 16; i++) mem[i] = 16'h0;
    mem[0] = 16'h1234;
    mem[4] = 16'h0F0F;
    rst_n = 1'b0;
    src_en = '0; ld_en = '0; alu_fn = '0; mem_rd = 1'b0; mem_wr = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (3) @(posedge clk);

    // R1 reset state
    obs(SRC_PC,  16'h0, "R1 pc");
    obs(SRC_IR,  16'h0, "R1 ir");
    obs(SRC_AC,  16'h0, "R1 ac");
    obs(SRC_MBR, 16'h0, "R1 mbr");
    obs(SRC_Z,   16'h0, "R1 z");
    mid(); chk("R1 mem_addr", 32'(mem_addr), 32'h0);
    chk("R1 ir_opcode", 32'(ir_opcode), 32'h0);

    // R2 idle bus
    idle(); mid();
    chk("R2 idle bus", 32'(bus_val), 32'h0);
    chk("R2 no err", 32'(bus_err), 32'h0);

    // R6 read memory word 0 into MBR
    apply(5'b0, 7'b0, 2'b00, 1'b1, 1'b0); mid();
    chk("R6 mem_re", 32'(mem_re), 32'h1);
    obs(SRC_MBR, 16'h1234, "R6 mbr from memory");

    // R3 fan-out to several destinations, R11 address field
    apply(s1(SRC_MBR), L_PC | L_IR | L_AC, 2'b00, 1'b0, 1'b0);
    obs(SRC_PC, 16'h1234, "R3 pc load");
    obs(SRC_AC, 16'h1234, "R3 ac load");
    obs(SRC_IR, 16'h0234, "R11 ir address field");
    mid(); chk("R11 ir_opcode", 32'(ir_opcode), 32'h1);

    // R6 MAR drives address
    apply(s1(SRC_IR), L_MAR, 2'b00, 1'b0, 1'b0);
    idle(); mid();
    chk("R6 mem_addr", 32'(mem_addr), 32'h234);

    // R4 ALU functions with Y = 0F0F, AC = 1234
    apply(5'b0, 7'b0, 2'b00, 1'b1, 1'b0);
    apply(s1(SRC_MBR), L_Y, 2'b00, 1'b0, 1'b0);
    apply(5'b0, L_Z, 2'b00, 1'b0, 1'b0);
    obs(SRC_Z, 16'h2143, "R4 add");
    apply(5'b0, L_Z, 2'b01, 1'b0, 1'b0);
    obs(SRC_Z, 16'h0204, "R4 and");
    apply(5'b0, L_Z, 2'b10, 1'b0, 1'b0);
    obs(SRC_Z, 16'h0F0F, "R4 pass y");
    apply(5'b0, L_Z, 2'b11, 1'b0, 1'b0);
    obs(SRC_Z, 16'hEDCB, "R4 not ac");

    // R5 Z holds and drives the bus later
    idle(); idle();
    obs(SRC_Z, 16'hEDCB, "R5 z hold");
    apply(s1(SRC_Z), L_AC, 2'b00, 1'b0, 1'b0);
    obs(SRC_AC, 16'hEDCB, "R5 ac from z");

    // R7 memory write
    apply(s1(SRC_AC), L_MBR, 2'b00, 1'b0, 1'b0);
    apply(5'b0, 7'b0, 2'b00, 1'b0, 1'b1); mid();
    chk("R7 mem_we", 32'(mem_we), 32'h1);
    chk("R7 mem_wdata", 32'(mem_wdata), 32'hEDCB);
    idle(); mid();
    chk("R7 memory content", 32'(mem[4]), 32'hEDCB);

    // R8 two drivers
    apply(s1(SRC_AC) | s1(SRC_PC), L_Y | L_MAR | L_AC, 2'b00, 1'b0, 1'b1); mid();
    chk("R8 bus_err", 32'(bus_err), 32'h1);
    chk("R8 mem_we suppressed", 32'(mem_we), 32'h0);
    idle(); mid();
    chk("R8 mar kept", 32'(mem_addr), 32'h234);
    obs(SRC_AC, 16'hEDCB, "R8 ac kept");
    apply(5'b0, L_Z, 2'b10, 1'b0, 1'b0);
    obs(SRC_Z, 16'h0F0F, "R8 y kept");

    // R9 same register read and write
    apply(s1(SRC_Z), L_Z, 2'b00, 1'b0, 1'b0); mid();
    chk("R9 z rw err", 32'(bus_err), 32'h1);
    obs(SRC_Z, 16'h0F0F, "R9 z kept");
    apply(s1(SRC_AC), L_AC, 2'b00, 1'b0, 1'b0); mid();
    chk("R9 ac rw err", 32'(bus_err), 32'h1);
    obs(SRC_AC, 16'hEDCB, "R9 ac kept");
    apply(5'b0, L_MBR, 2'b00, 1'b1, 1'b0); mid();
    chk("R9 mbr clash err", 32'(bus_err), 32'h1);
    chk("R9 mem_re suppressed", 32'(mem_re), 32'h0);
    obs(SRC_MBR, 16'hEDCB, "R9 mbr kept");

    // R10 add to memory: AC = EDCB + mem[4] (EDCB)
    apply(s1(SRC_IR), L_MAR, 2'b00, 1'b0, 1'b0);
    apply(5'b0, 7'b0, 2'b00, 1'b1, 1'b0);
    apply(s1(SRC_MBR), L_Y, 2'b00, 1'b0, 1'b0);
    apply(5'b0, L_Z, 2'b00, 1'b0, 1'b0);
    apply(s1(SRC_Z), L_AC, 2'b00, 1'b0, 1'b0);
    obs(SRC_AC, 16'hDB96, "R10 add to memory");

    idle(); mid();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule